// File: doc/BRIEF.md
# Keyed Write-Protection Sequence Guard

This block sits between the decoder that turns bus strobes into single accepted writes and the engine that loads and programs an array page. Every accepted write (an 11-bit address and an 8-bit byte) passes through it. The guard checks each write against two fixed key sequences. A three-write key arms protection. A six-write key removes protection. While protection is armed, ordinary writes are accepted and then discarded. The only way to program the array is a keyed burst: the arming key, followed inside the same page-load window by up to `PAGE_BYTES` data writes. Key writes themselves never reach the array.

A key write is held back until the guard knows whether it belongs to a real key. When a partial key breaks off while the block is unprotected, the held writes and the write that broke the key are sent downstream in their original order. While protected, a broken key is thrown away. The page timer's expiry pulse closes a keyed burst and cancels a partial key. The protection flag has its own power-on reset. The ordinary reset leaves it alone, which models a flag that survives power cycles.

Both the input and output write streams use valid/ready. Back-pressure rules: `wr_ready` follows `arr_ready` whenever the offered write would go straight through. `wr_ready` is high for any write that is held or discarded. `wr_ready` is low while held writes are being replayed and in any cycle where `win_expired` is high. A valid output write holds its address and data until `arr_ready` is seen.

Top module: `wp_seq_guard`

## Requirements
- R1: After power-on reset, `protected_o` is 0, `arr_valid` is 0 and `wr_ready` is 1.
- R2: While unprotected and idle, a write that is not the first key step (AAh to 555h) appears on the array port with unchanged address and data, and `wr_ready` equals `arr_ready` while it is offered.
- R3: The arming key (AAh to 555h, then 55h to 2AAh, then A0h to 555h) sets `protected_o`, and none of its writes reaches the array.
- R4: While protected, an ordinary write is accepted and never reaches the array.
- R5: After the arming key, up to `PAGE_BYTES` (64) further writes are forwarded to the array, and protection stays set. Writes beyond that count in the same window are dropped.
- R6: A `win_expired` pulse ends a keyed burst, so later writes are treated as ordinary writes again.
- R7: The disarming key (AAh to 555h, 55h to 2AAh, 80h to 555h, AAh to 555h, 55h to 2AAh, 20h to 555h) clears `protected_o`, and none of its writes reaches the array.
- R8: While unprotected, a write that breaks a partial key causes the held key writes and then the breaking write to be replayed to the array in order. `wr_ready` is 0 during the replay, and each replayed write holds while `arr_ready` is 0.
- R9: While protected, a write that breaks a partial key discards the partial key and that write, and leaves protection set.
- R10: `win_expired` during a partial key cancels it. The held writes are replayed if unprotected or dropped if protected, and the next write is matched from the first key step.
- R11: In a cycle where `win_expired` is 1, `wr_ready` is 0, so the expiry is handled before any write offered in that cycle.
- R12: The ordinary reset `rst_n` does not change `protected_o`. Only `por_n` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Ordinary active-low reset of sequencing state |
| por_n | input | 1 | Active-low power-on reset of the protection flag |
| wr_valid | input | 1 | Incoming write offered |
| wr_ready | output | 1 | Incoming write accepted when high with wr_valid |
| wr_addr | input | 11 | Incoming write address |
| wr_data | input | 8 | Incoming write byte |
| win_expired | input | 1 | Page-load window expiry pulse from the page timer |
| arr_valid | output | 1 | Write offered to the page engine |
| arr_ready | input | 1 | Page engine accepts the offered write |
| arr_addr | output | 11 | Address of the write to the page engine |
| arr_data | output | 8 | Byte of the write to the page engine |
| protected_o | output | 1 | Protection flag |

## Verification
Two events can arrive in the same cycle: the page-window expiry and a new incoming write. One case is a partial key or keyed burst in progress when this happens. The bench raises `win_expired` while it holds `wr_valid` high with a fresh write. It requires `wr_ready` to be low in that cycle. After the expiry it requires the write to be matched from idle. A second pairing, replay against downstream stall, is judged by holding `arr_ready` low right after a broken key. The bench checks that input is refused and that the first held key write is presented unchanged.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  localparam int ADDR_W  = 11;
  localparam int DATA_W  = 8;
  localparam int EN_LEN  = 3;
  localparam int DIS_LEN = 6;
  localparam int CNT_W   = $clog2(DIS_LEN + 1);

  localparam logic [ADDR_W-1:0] KEY_ADDR_A = 11'h555;
  localparam logic [ADDR_W-1:0] KEY_ADDR_B = 11'h2AA;
  localparam logic [DATA_W-1:0] ARM_BYTE   = 8'hA0;

  typedef struct packed {
    logic [ADDR_W-1:0] a;
    logic [DATA_W-1:0] d;
  } wr_t;

  typedef enum logic [1:0] {S_IDLE, S_KEY, S_KEYED, S_REPLAY} st_t;

  // expected write at each step of the longer (disarming) key
  function automatic wr_t key_step(int idx);
    wr_t w;
    case (idx)
      0, 3:    w = '{a: KEY_ADDR_A, d: 8'hAA};
      1, 4:    w = '{a: KEY_ADDR_B, d: 8'h55};
      2:       w = '{a: KEY_ADDR_A, d: 8'h80};
      default: w = '{a: KEY_ADDR_A, d: 8'h20};
    endcase
    return w;
  endfunction
endpackage

// File: rtl/wpg_key_match.sv
module wpg_key_match
  import wpg_pkg::*;
(
  input  logic [CNT_W-1:0] step,
  input  wr_t              cur,
  output logic             hit,
  output logic             en_done,
  output logic             dis_done
);
  logic [DIS_LEN-1:0] step_eq;
  logic [DIS_LEN-1:0] step_oh;
  logic               dis_hit;

  for (genvar i = 0; i < DIS_LEN; i++) begin : g_step
    assign step_eq[i] = (cur == key_step(i));
  end

  assign step_oh  = DIS_LEN'(1) << step;
  assign dis_hit  = |(step_eq & step_oh);
  assign en_done  = (step == CNT_W'(EN_LEN - 1)) && (cur == '{a: KEY_ADDR_A, d: ARM_BYTE});
  assign dis_done = (step == CNT_W'(DIS_LEN - 1)) && dis_hit;
  assign hit      = dis_hit || en_done;
endmodule

// File: rtl/wpg_hold_buf.sv
module wpg_hold_buf
  import wpg_pkg::*;
#(
  parameter int DEPTH = DIS_LEN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  wr_t              din,
  input  logic             pop,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt,
  output wr_t              head,
  output logic             last
);
  localparam int SLOTS = 1 << CNT_W;

  wr_t              mem [SLOTS];
  logic [CNT_W-1:0] rptr;

  always_ff @(posedge clk) begin
    if (push) mem[cnt] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      rptr <= '0;
    end else if (clear) begin
      cnt  <= '0;
      rptr <= '0;
    end else begin
      if (push) cnt  <= cnt + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
    end
  end

  assign head = mem[rptr];
  assign last = (rptr == cnt - 1'b1);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt < CNT_W'(DEPTH)));
  p_pop_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (rptr < cnt));
endmodule

// File: rtl/wpg_prot_flag.sv
module wpg_prot_flag (
  input  logic clk,
  input  logic por_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)   q <= 1'b0;
    else if (clr) q <= 1'b0;
    else if (set) q <= 1'b1;
  end

  p_set_r3: assert property (@(posedge clk) disable iff (!por_n) set |=> q);
  p_clr_r7: assert property (@(posedge clk) disable iff (!por_n) clr |=> !q);
  p_hold_r12: assert property (@(posedge clk) disable iff (!por_n)
    (!set && !clr) |=> $stable(q));
endmodule

// File: rtl/wp_seq_guard.sv
module wp_seq_guard
  import wpg_pkg::*;
#(
  parameter int PAGE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              win_expired,
  output logic              arr_valid,
  input  logic              arr_ready,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data,
  output logic              protected_o
);
  localparam int KC_W = $clog2(PAGE_BYTES + 1);
  localparam logic [KC_W-1:0] KC_MAX = KC_W'(PAGE_BYTES);

  st_t              st, st_n;
  logic [KC_W-1:0]  kcnt, kcnt_n;
  wr_t              cur, head;
  logic [CNT_W-1:0] step;
  logic             hit, en_done, dis_done, last;
  logic             push, pop, clear, set, clr;
  logic             fwd_now, acc;

  assign cur = '{a: wr_addr, d: wr_data};

  wpg_key_match u_match (
    .step(step), .cur(cur), .hit(hit), .en_done(en_done), .dis_done(dis_done)
  );

  wpg_hold_buf #(.DEPTH(DIS_LEN)) u_buf (
    .clk(clk), .rst_n(rst_n), .push(push), .din(cur), .pop(pop),
    .clear(clear), .cnt(step), .head(head), .last(last)
  );

  wpg_prot_flag u_flag (
    .clk(clk), .por_n(por_n), .set(set), .clr(clr), .q(protected_o)
  );

  // would the offered write go straight to the array
  always_comb begin
    case (st)
      S_IDLE:  fwd_now = !hit && !protected_o;
      S_KEYED: fwd_now = (kcnt < KC_MAX);
      default: fwd_now = 1'b0;
    endcase
  end

  assign wr_ready  = !win_expired && (st != S_REPLAY) && (!fwd_now || arr_ready);
  assign acc       = wr_valid && wr_ready;
  assign arr_valid = (st == S_REPLAY) || (wr_valid && !win_expired && fwd_now);
  assign arr_addr  = (st == S_REPLAY) ? head.a : wr_addr;
  assign arr_data  = (st == S_REPLAY) ? head.d : wr_data;

  always_comb begin
    st_n   = st;
    kcnt_n = kcnt;
    push   = 1'b0;
    pop    = 1'b0;
    clear  = 1'b0;
    set    = 1'b0;
    clr    = 1'b0;
    case (st)
      S_IDLE, S_KEY: begin
        if (acc) begin
          if (en_done) begin
            set = 1'b1; clear = 1'b1; st_n = S_KEYED; kcnt_n = '0;
          end else if (dis_done) begin
            clr = 1'b1; clear = 1'b1; st_n = S_IDLE;
          end else if (hit) begin
            push = 1'b1; st_n = S_KEY;
          end else if (st == S_KEY) begin
            if (protected_o) begin
              clear = 1'b1; st_n = S_IDLE;
            end else begin
              push = 1'b1; st_n = S_REPLAY;
            end
          end
        end else if (win_expired && st == S_KEY) begin
          if (protected_o) begin
            clear = 1'b1; st_n = S_IDLE;
          end else begin
            st_n = S_REPLAY;
          end
        end
      end
      S_KEYED: begin
        if (win_expired)        st_n = S_IDLE;
        else if (acc && fwd_now) kcnt_n = kcnt + 1'b1;
      end
      default: begin
        if (arr_ready) begin
          if (last) begin
            clear = 1'b1; st_n = S_IDLE;
          end else begin
            pop = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      kcnt <= '0;
    end else begin
      st   <= st_n;
      kcnt <= kcnt_n;
    end
  end

  p_arm_sets_r3: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (acc && en_done && st != S_KEYED) |=> protected_o);
  p_disarm_clears_r7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (acc && dis_done && st != S_KEYED) |=> !protected_o);
  p_page_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_KEYED) |-> (kcnt <= KC_MAX));
  p_expire_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_expired && st == S_KEYED) |=> (st == S_IDLE));
  p_replay_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_REPLAY && !arr_ready) |=> (arr_valid && $stable(arr_addr) && $stable(arr_data)));
  p_prot_break_r9: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (acc && st == S_KEY && !hit && protected_o) |=> (st == S_IDLE && protected_o));
endmodule

// File: tb/wp_seq_guard_bench.sv
module wp_seq_guard_bench;
  localparam int PER = 10;
  localparam int NT  = 28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, por_n = 1'b0;
  logic        wr_valid = 1'b0, win_expired = 1'b0, arr_ready = 1'b1;
  logic [10:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        wr_ready, arr_valid, protected_o;
  logic [10:0] arr_addr;
  logic [7:0]  arr_data;

  int total = 0, bad = 0, ncap = 0;
  logic [10:0] cap_a [256];
  logic [7:0]  cap_d [256];

  always #(PER/2) clk = ~clk;

  wp_seq_guard u_wp_seq_guard (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .win_expired(win_expired),
    .arr_valid(arr_valid), .arr_ready(arr_ready), .arr_addr(arr_addr),
    .arr_data(arr_data), .protected_o(protected_o)
  );

  // entry: [21] expiry pulse, [20] reaches array, [19] flag afterwards, [18:8] addr, [7:0] data
  function automatic logic [21:0] ent(bit e, bit f, bit p, logic [10:0] a, logic [7:0] d);
    return {e, f, p, a, d};
  endfunction

  localparam logic [21:0] TBL [NT] = '{
    ent(0,1,0,11'h123,8'h5A), ent(0,1,0,11'h555,8'hAA), ent(0,1,0,11'h2AA,8'h55),
    ent(0,1,0,11'h100,8'h11), ent(0,1,0,11'h555,8'hAA), ent(1,0,0,11'h000,8'h00),
    ent(0,0,0,11'h555,8'hAA), ent(0,0,0,11'h2AA,8'h55), ent(0,0,1,11'h555,8'hA0),
    ent(0,1,1,11'h640,8'h01), ent(0,1,1,11'h641,8'h02), ent(1,0,1,11'h000,8'h00),
    ent(0,0,1,11'h642,8'h03), ent(0,0,1,11'h555,8'hAA), ent(0,0,1,11'h2AA,8'h55),
    ent(0,0,1,11'h300,8'h77), ent(0,0,1,11'h555,8'hAA), ent(1,0,1,11'h000,8'h00),
    ent(0,0,1,11'h222,8'h33), ent(0,0,1,11'h555,8'hAA), ent(0,0,1,11'h2AA,8'h55),
    ent(0,0,1,11'h555,8'h80), ent(0,0,1,11'h555,8'hAA), ent(0,0,1,11'h2AA,8'h55),
    ent(0,0,0,11'h555,8'h20), ent(0,1,0,11'h7FF,8'hEE), ent(0,1,0,11'h555,8'hAA),
    ent(0,1,0,11'h555,8'hA0)
  };

  // capture array-side handshakes just before each rising edge
  always @(negedge clk) begin
    #(PER/2 - 1);
    if (arr_valid && arr_ready && ncap < 256) begin
      cap_a[ncap] = arr_addr;
      cap_d[ncap] = arr_data;
      ncap++;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(logic [10:0] a, logic [7:0] d);
    logic acc = 1'b0;
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    while (!acc) begin
      #1 acc = wr_ready;
      @(posedge clk);
      if (!acc) @(negedge clk);
    end
    #1 wr_valid = 1'b0;
  endtask

  task automatic expire();
    @(negedge clk); win_expired = 1'b1;
    @(negedge clk); win_expired = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(PER * 100000);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int exp_n, base;
    logic [10:0] ea [32];
    logic [7:0]  ed [32];
    idle(3);
    por_n = 1'b1; rst_n = 1'b1;
    #1;
    chk(protected_o == 1'b0, "R1", "flag after reset", protected_o, 0);
    chk(arr_valid == 1'b0, "R1", "arr_valid after reset", arr_valid, 0);
    chk(wr_ready == 1'b1, "R1", "wr_ready after reset", wr_ready, 1);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10
    exp_n = 0;
    for (int i = 0; i < NT; i++) begin
      if (TBL[i][21]) expire();
      else send(TBL[i][18:8], TBL[i][7:0]);
      if (TBL[i][20]) begin
        ea[exp_n] = TBL[i][18:8]; ed[exp_n] = TBL[i][7:0]; exp_n++;
      end
      idle(3);
      chk(protected_o == TBL[i][19], "R3/R7 table flag", $sformatf("entry %0d", i),
          protected_o, TBL[i][19]);
    end
    idle(8);
    chk(ncap == exp_n, "R2/R4/R8/R9", "forwarded count", ncap, exp_n);
    for (int i = 0; i < exp_n && i < ncap; i++)
      chk(cap_a[i] == ea[i] && cap_d[i] == ed[i], "R8 order", $sformatf("item %0d", i),
          {cap_a[i], cap_d[i]}, {ea[i], ed[i]});

    // R11: expiry and a fresh write in the same cycle
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 11'h555; wr_data = 8'hAA; win_expired = 1'b1;
    #1 chk(wr_ready == 1'b0, "R11", "ready during expiry", wr_ready, 0);
    @(negedge clk);
    win_expired = 1'b0; wr_valid = 1'b0;
    idle(2);
    // the pending 555/A0 from the table was cleared by replay; now step-0 write then break
    base = ncap;
    send(11'h555, 8'hAA);
    send(11'h010, 8'h01);
    idle(6);
    chk(ncap == base + 2, "R10", "restart from idle", ncap, base + 2);

    // R2 back-pressure on a direct write
    base = ncap;
    @(negedge clk);
    arr_ready = 1'b0; wr_valid = 1'b1; wr_addr = 11'h0AB; wr_data = 8'hCD;
    #1;
    chk(wr_ready == 1'b0, "R2", "ready follows arr_ready", wr_ready, 0);
    chk(arr_valid && arr_addr == 11'h0AB && arr_data == 8'hCD, "R2", "pass-through",
        {arr_addr, arr_data}, {11'h0AB, 8'hCD});
    @(negedge clk);
    arr_ready = 1'b1;
    @(posedge clk); #1 wr_valid = 1'b0;
    idle(2);
    chk(ncap == base + 1 && cap_a[base] == 11'h0AB, "R2", "delivered once", ncap, base + 1);

    // R8 replay under downstream stall
    base = ncap;
    send(11'h555, 8'hAA);
    send(11'h2AA, 8'h55);
    @(negedge clk); arr_ready = 1'b0;
    send(11'h111, 8'h22);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 11'h033; wr_data = 8'h44;
    #1;
    chk(wr_ready == 1'b0, "R8", "input held in replay", wr_ready, 0);
    chk(arr_valid && arr_addr == 11'h555 && arr_data == 8'hAA, "R8", "first held write",
        {arr_addr, arr_data}, {11'h555, 8'hAA});
    wr_valid = 1'b0;
    idle(2);
    arr_ready = 1'b1;
    idle(6);
    chk(ncap == base + 3, "R8", "replay count", ncap, base + 3);
    chk(cap_a[base+1] == 11'h2AA && cap_d[base+2] == 8'h22, "R8", "replay order",
        {cap_a[base+1], cap_d[base+2]}, {11'h2AA, 8'h22});

    // R5: keyed burst limited to 64 bytes
    send(11'h555, 8'hAA); send(11'h2AA, 8'h55); send(11'h555, 8'hA0);
    base = ncap;
    for (int i = 0; i < 65; i++) send(11'h040 + 11'(i), 8'(i));
    idle(3);
    chk(ncap == base + 64, "R5", "keyed burst cap", ncap, base + 64);
    chk(protected_o == 1'b1, "R5", "flag kept in burst", protected_o, 1);
    expire();
    base = ncap;
    send(11'h040, 8'h99);
    idle(3);
    chk(ncap == base, "R6", "write after window closed", ncap, base);
    chk(ncap == base, "R4", "protected write dropped", ncap, base);

    // R12: ordinary reset keeps the flag, power-on reset clears it
    @(negedge clk); rst_n = 1'b0;
    idle(2); rst_n = 1'b1;
    idle(1);
    chk(protected_o == 1'b1, "R12", "flag across rst_n", protected_o, 1);
    base = ncap;
    send(11'h050, 8'h12);
    idle(3);
    chk(ncap == base, "R12", "still blocking after rst_n", ncap, base);
    @(negedge clk); por_n = 1'b0; rst_n = 1'b0;
    idle(2); por_n = 1'b1; rst_n = 1'b1;
    #1 chk(protected_o == 1'b0, "R12", "flag after por_n", protected_o, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule